// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache with Victim Buffer

This block is a write-back data cache. Its main array is direct mapped: each block of memory may reside in exactly one line, picked by the low bits of its block address. Beside that array sits a small fully associative victim buffer. Lines pushed out of the array are parked there, so two blocks that fight over one line can be swapped back and forth without touching memory.

The processor holds a request (valid, write flag, byte address, byte enables, write data) until the block raises `rsp_ready_o` for one cycle. A read returns the whole block. On a miss in both structures, the block talks to memory through a block-wide request and acknowledge handshake. A dirty line reaches memory only when it drops out of the victim buffer. Address width, line-index width and victim depth are parameters. The victim depth is meant to lie between 4 and 16. A 14-bit index gives the classic 8/14/2 split of a 24-bit address. The default index is kept at 8 bits so that the storage stays small at elaboration.

Top module: `dmv_cache`

## Requirements
- R1: The block address is `req_addr_i[ADDR_W-1:OFF_W]`. Its low `IDX_W` bits select the line, and the remaining upper bits form the tag. The byte-in-block bits `req_addr_i[OFF_W-1:0]` play no part in lookup. Two addresses that differ only in those bits hit the same line, and a different tag at the same index never hits.
- R2: On a read hit in the array, `rsp_ready_o` is high in the cycle after the request is accepted, `rsp_rdata_o` carries the stored block, and no memory request is made.
- R3: A write hit replaces byte i (bits 8i+7..8i) with the matching byte of `req_wdata_i` wherever `req_be_i[i]` is 1, keeps the other bytes, marks the line dirty, and makes no memory request.
- R4: Reset clears every valid and dirty bit. While reset is asserted, `rsp_ready_o` and `mem_req_o` are 0, and the first access to any block after reset is a miss.
- R5: A valid line displaced from the array moves into the victim buffer with its dirty flag. The displacement itself causes no memory write, and no two valid victim entries hold the same block.
- R6: On an array miss that hits the victim buffer, the entry and the array line trade places together with their dirty flags. No memory request is made, and `rsp_ready_o` rises two cycles after acceptance.
- R7: On a miss in both structures, exactly one memory read is issued for the requested block address. The returned data is installed clean, and the original access then completes with correct data.
- R8: Displaced lines fill victim slots in round-robin order of insertion, and a swap leaves that order unchanged. If the slot about to be reused holds a dirty line, that line is written to memory (its block address and data) before the fill read. A clean line in that slot is dropped with no write.
- R9: `mem_req_o` stays high, with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged, until `mem_ack_i` is seen. `mem_addr_o` is a block address.
- R10: `rsp_ready_o` is a one-cycle pulse, and the cycle after it accepts no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; held until `rsp_ready_o` |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_be_i | input | 2**OFF_W | Byte enables for writes |
| req_wdata_i | input | 8*2**OFF_W | Write data |
| rsp_ready_o | output | 1 | Access complete (one-cycle pulse) |
| rsp_rdata_o | output | 8*2**OFF_W | Block read data, valid with `rsp_ready_o` |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write-back |
| mem_addr_o | output | ADDR_W-OFF_W | Memory block address |
| mem_wdata_o | output | 8*2**OFF_W | Write-back data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 8*2**OFF_W | Fill data, valid with `mem_ack_i` |

## Verification
An array hit is due one cycle after acceptance and a victim-buffer hit two cycles after. A miss completes one cycle after the fill acknowledge reinstalls the line, so its timing depends on memory. The bench therefore judges a miss by the count and addresses of memory transfers rather than by cycle. The bench drives on the falling edge and counts falling edges from the drive edge to `rsp_ready_o`, so the hit and swap latencies are compared exactly. A behavioural model of array, victim FIFO and memory image predicts the class, traffic and data of each access, and the falling edge after each pulse confirms that `rsp_ready_o` has dropped.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } dmv_state_e;
endpackage

// File: rtl/dmv_line_store.sv
module dmv_line_store #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              we_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wdirty_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (we_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= wdirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[idx_i]  <= wtag_i;
      data_q[idx_i] <= wdata_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign data_o  = data_q[idx_i];
endmodule

// File: rtl/dmv_victim_buf.sv
module dmv_victim_buf #(
  parameter int BLK_W  = 22,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  look_blk_i,
  output logic              hit_o,
  output logic [PTR_W-1:0]  hit_idx_o,
  output logic [DATA_W-1:0] hit_data_o,
  output logic              hit_dirty_o,
  output logic [PTR_W-1:0]  head_idx_o,
  output logic              head_valid_o,
  output logic              head_dirty_o,
  output logic [BLK_W-1:0]  head_blk_o,
  output logic [DATA_W-1:0] head_data_o,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  widx_i,
  input  logic              wvalid_i,
  input  logic [BLK_W-1:0]  wblk_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wdirty_i,
  input  logic              push_i
);
  logic [DEPTH-1:0]  valid_q, dirty_q, match;
  logic [BLK_W-1:0]  blk_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (blk_q[g] == look_blk_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hit_idx_o = PTR_W'(i);
    end
  end

  assign hit_o        = |match;
  assign hit_data_o   = data_q[hit_idx_o];
  assign hit_dirty_o  = dirty_q[hit_idx_o];
  assign head_idx_o   = ptr_q;
  assign head_valid_o = valid_q[ptr_q];
  assign head_dirty_o = dirty_q[ptr_q];
  assign head_blk_o   = blk_q[ptr_q];
  assign head_data_o  = data_q[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (we_i) begin
        valid_q[widx_i] <= wvalid_i;
        dirty_q[widx_i] <= wdirty_i && wvalid_i;
      end
      if (push_i) ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      blk_q[widx_i]  <= wblk_i;
      data_q[widx_i] <= wdata_i;
    end
  end

  // R5: a block never sits in two victim slots
  always_comb begin
    if (rst_ni) begin
      a_r5_unique_entry: assert ($countones(match) <= 1)
        else $error("victim buffer holds duplicate block");
    end
  end
endmodule

// File: rtl/dmv_cache.sv
module dmv_cache
  import dmv_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int OFF_W    = 2,
  parameter int IDX_W    = 8,
  parameter int VB_DEPTH = 4,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int TAG_W  = BLK_W - IDX_W,
  localparam int BE_W   = 1 << OFF_W,
  localparam int DATA_W = 8 * BE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int PTR_W = $clog2(VB_DEPTH);

  dmv_state_e        state_q;
  logic [BLK_W-1:0]  miss_blk_q;
  logic              ready_q;
  logic [DATA_W-1:0] rdata_q;

  logic [BLK_W-1:0]  req_blk, look_blk;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              unused_off;

  logic              l_valid, l_dirty, l_we, l_wdirty;
  logic [TAG_W-1:0]  l_tag;
  logic [DATA_W-1:0] l_data, l_wdata, merged;

  logic              v_hit, v_dirty, v_we, v_wvalid, v_push;
  logic [PTR_W-1:0]  v_idx, head_idx, v_widx;
  logic [DATA_W-1:0] v_data, head_data;
  logic              head_valid, head_dirty;
  logic [BLK_W-1:0]  head_blk;

  logic              accept, c_hit, do_swap, fill_done;

  assign req_blk    = req_addr_i[ADDR_W-1:OFF_W];
  assign unused_off = ^req_addr_i[OFF_W-1:0];
  // miss handling reuses the latched block so the victim line stays addressed
  assign look_blk   = (state_q == ST_IDLE) ? req_blk : miss_blk_q;
  assign look_idx   = look_blk[IDX_W-1:0];
  assign look_tag   = look_blk[BLK_W-1:IDX_W];

  dmv_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_i    (look_idx),
    .valid_o  (l_valid),
    .dirty_o  (l_dirty),
    .tag_o    (l_tag),
    .data_o   (l_data),
    .we_i     (l_we),
    .wtag_i   (look_tag),
    .wdata_i  (l_wdata),
    .wdirty_i (l_wdirty)
  );

  dmv_victim_buf #(.BLK_W(BLK_W), .DATA_W(DATA_W), .DEPTH(VB_DEPTH)) u_vbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .look_blk_i   (look_blk),
    .hit_o        (v_hit),
    .hit_idx_o    (v_idx),
    .hit_data_o   (v_data),
    .hit_dirty_o  (v_dirty),
    .head_idx_o   (head_idx),
    .head_valid_o (head_valid),
    .head_dirty_o (head_dirty),
    .head_blk_o   (head_blk),
    .head_data_o  (head_data),
    .we_i         (v_we),
    .widx_i       (v_widx),
    .wvalid_i     (v_wvalid),
    .wblk_i       ({l_tag, look_idx}),
    .wdata_i      (l_data),
    .wdirty_i     (l_dirty),
    .push_i       (v_push)
  );

  assign accept    = (state_q == ST_IDLE) && req_valid_i && !ready_q;
  assign c_hit     = l_valid && (l_tag == look_tag);
  assign do_swap   = accept && !c_hit && v_hit;
  assign fill_done = (state_q == ST_FILL) && mem_ack_i;

  always_comb begin
    merged = l_data;
    for (int b = 0; b < BE_W; b++) begin
      if (req_be_i[b]) merged[8*b +: 8] = req_wdata_i[8*b +: 8];
    end
  end

  always_comb begin
    l_we     = 1'b0;
    l_wdata  = merged;
    l_wdirty = 1'b1;
    if (accept && c_hit && req_we_i) begin
      l_we = 1'b1;
    end else if (do_swap) begin
      l_we     = 1'b1;
      l_wdata  = v_data;
      l_wdirty = v_dirty;
    end else if (fill_done) begin
      l_we     = 1'b1;
      l_wdata  = mem_rdata_i;
      l_wdirty = 1'b0;
    end
  end

  // swap writes the hit slot; a fill pushes the old line into the head slot
  assign v_we     = do_swap || (fill_done && l_valid);
  assign v_widx   = do_swap ? v_idx : head_idx;
  assign v_wvalid = do_swap ? l_valid : 1'b1;
  assign v_push   = fill_done && l_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      miss_blk_q <= '0;
      ready_q    <= 1'b0;
      rdata_q    <= '0;
    end else begin
      ready_q <= accept && c_hit;
      if (accept && c_hit) rdata_q <= req_we_i ? merged : l_data;
      unique case (state_q)
        ST_IDLE: if (accept && !c_hit && !v_hit) begin
          miss_blk_q <= req_blk;
          state_q    <= (l_valid && head_valid && head_dirty) ? ST_WB : ST_FILL;
        end
        ST_WB:   if (mem_ack_i) state_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_ready_o = ready_q;
  assign rsp_rdata_o = rdata_q;
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ? head_blk : miss_blk_q;
  assign mem_wdata_o = head_data;

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_wdata_o));

  a_r10_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |=> !rsp_ready_o);

  a_r2_hit_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && c_hit |=> rsp_ready_o && !mem_req_o);

  a_r6_swap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_swap |=> !mem_req_o ##1 rsp_ready_o);

  a_r8_wb_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> head_valid && head_dirty);

  a_r7_fill_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> !mem_req_o ##1 rsp_ready_o);
endmodule

// File: tb/dmv_cache_bench.sv
module dmv_cache_bench;
  localparam int BIDX   = 2;
  localparam int LINES  = 1 << BIDX;
  localparam int VBD    = 4;
  localparam int ADDR_W = 24;
  localparam int BLK_W  = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic        mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  dmv_cache #(.ADDR_W(ADDR_W), .OFF_W(2), .IDX_W(BIDX), .VB_DEPTH(VBD)) u_dmv_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_ready_o(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] arch    [int];
  logic [31:0] mem_img [int];

  function automatic logic [31:0] init_val(int blk);
    return (32'(blk) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] arch_get(int blk);
    return arch.exists(blk) ? arch[blk] : init_val(blk);
  endfunction
  function automatic logic [31:0] mem_get(int blk);
    return mem_img.exists(blk) ? mem_img[blk] : init_val(blk);
  endfunction

  task automatic chk(string rq, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory responder, two-cycle latency
  int rd_cnt = 0, wr_cnt = 0, lat = 0;
  int last_rd_blk = -1, last_wb_blk = -1;
  logic [21:0] first_addr;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat = 0;
    end else if (mem_req && rst_n) begin
      lat++;
      if (lat == 1) first_addr = mem_addr;
      if (lat == 2) begin
        chk("R9", "mem_addr held", mem_addr, first_addr);
        if (mem_we) begin
          wr_cnt++;
          last_wb_blk = int'(mem_addr);
          chk("R8", "write-back data", mem_wdata, arch_get(int'(mem_addr)));
          mem_img[int'(mem_addr)] = mem_wdata;
        end else begin
          rd_cnt++;
          last_rd_blk = int'(mem_addr);
          mem_rdata = mem_get(int'(mem_addr));
        end
        mem_ack = 1'b1;
      end
    end
  end

  // behavioural residency model
  bit c_valid [LINES];
  int c_blk   [LINES];
  bit c_dirty [LINES];
  bit v_valid [VBD];
  int v_blk   [VBD];
  bit v_dirty [VBD];
  int v_ptr = 0;

  task automatic access(bit we, int blk, logic [3:0] be, logic [31:0] wd, logic [1:0] off);
    int idx, kind, k, n, rd0, wr0, wb_blk;
    bit exp_wr, old_dirty;
    logic [31:0] exp_data;
    idx = blk % LINES;
    kind = 2; k = -1; exp_wr = 0; wb_blk = -1; old_dirty = 0;
    if (c_valid[idx] && c_blk[idx] == blk) kind = 0;
    else begin
      for (int i = 0; i < VBD; i++) if (v_valid[i] && v_blk[i] == blk) k = i;
      if (k >= 0) kind = 1;
    end
    if (kind == 1) begin
      int tb; bit td;
      tb = c_blk[idx]; td = c_dirty[idx];
      c_dirty[idx] = v_dirty[k]; c_blk[idx] = blk;
      v_valid[k] = c_valid[idx]; v_blk[k] = tb; v_dirty[k] = td;
      c_valid[idx] = 1;
    end else if (kind == 2) begin
      old_dirty = c_valid[idx] && c_dirty[idx];
      exp_wr = c_valid[idx] && v_valid[v_ptr] && v_dirty[v_ptr];
      wb_blk = v_blk[v_ptr];
      if (c_valid[idx]) begin
        v_valid[v_ptr] = 1; v_blk[v_ptr] = c_blk[idx]; v_dirty[v_ptr] = c_dirty[idx];
        v_ptr = (v_ptr + 1) % VBD;
      end
      c_valid[idx] = 1; c_blk[idx] = blk; c_dirty[idx] = 0;
    end
    if (we) begin
      exp_data = arch_get(blk);
      for (int b = 0; b < 4; b++) if (be[b]) exp_data[8*b +: 8] = wd[8*b +: 8];
      arch[blk] = exp_data;
      c_dirty[idx] = 1;
    end else exp_data = arch_get(blk);

    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = {22'(blk), off}; req_be = be; req_wdata = wd;
    n = 0;
    do begin @(negedge clk); n++; end while (!rsp_ready && n < 60);
    if (n >= 60) chk("R7", "watchdog on access", 0, 1);
    req_valid = 1'b0;
    chk(kind == 0 ? "R2" : (kind == 1 ? "R6" : "R7"), we ? "write result" : "read data",
        rsp_rdata, exp_data);
    if (kind == 0) begin
      chk("R2", "hit latency", n, 1);
      chk("R2", "hit mem traffic", (rd_cnt - rd0) + (wr_cnt - wr0), 0);
    end else if (kind == 1) begin
      chk("R6", "swap latency", n, 2);
      chk("R6", "swap mem traffic", (rd_cnt - rd0) + (wr_cnt - wr0), 0);
    end else begin
      chk("R7", "fill reads", rd_cnt - rd0, 1);
      chk("R7", "fill address", last_rd_blk, blk);
      chk(exp_wr ? "R8" : (old_dirty ? "R5" : "R8"), "write-backs", wr_cnt - wr0, int'(exp_wr));
      if (exp_wr) chk("R8", "write-back block", last_wb_blk, wb_blk);
    end
    @(negedge clk);
    chk("R10", "ready dropped", rsp_ready, 0);
  endtask

  initial begin
    int seed;
    for (int i = 0; i < LINES; i++) begin c_valid[i] = 0; c_dirty[i] = 0; c_blk[i] = 0; end
    for (int i = 0; i < VBD; i++) begin v_valid[i] = 0; v_dirty[i] = 0; v_blk[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R4", "ready in reset", rsp_ready, 0);
    chk("R4", "mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    // R4: cold start misses; R1: offset ignored
    access(0, 'h10, 4'h0, 0, 2'd0);
    access(0, 'h10, 4'h0, 0, 2'd3);
    // R3: partial write then read back
    access(1, 'h10, 4'b0011, 32'hCAFE_BEEF, 2'd1);
    access(0, 'h10, 4'h0, 0, 2'd0);
    // R1/R5: same index, other tag displaces dirty line with no write
    access(0, 'h14, 4'h0, 0, 2'd0);
    // R6: ping-pong served by swaps
    access(0, 'h10, 4'h0, 0, 2'd2);
    access(1, 'h14, 4'b1000, 32'h7700_0000, 2'd0);
    access(0, 'h10, 4'h0, 0, 2'd0);
    // R8: fill the buffer with one index, then force slot reuse
    for (int t = 6; t < 14; t++) access(t % 2, 'h10 + 4 * t, 4'b0101, 32'h1100_2200 + t, 2'd0);
    // mixed traffic
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      int blk;
      seed = seed * 1103515245 + 12345;
      blk = ((seed >>> 8) & 32'h17);
      access((seed >>> 20) % 3 == 0, blk, 4'((seed >>> 12) & 4'hF), seed ^ 32'hA5A5_0F0F,
             2'((seed >>> 4) & 2'h3));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule